// File: doc/BRIEF.md
# Memory-Mapped Calendar Real-Time Clock

This block keeps wall-clock time for software: seconds, minutes, hours, day of month, month, year within the century and century, all held as plain binary fields. Software reaches it through a small word-addressed register window. Two packed time words carry the seven fields, and a control word turns counting on and off. A separate control bit opens the time words for writing.

A prescaler divides the system clock down to a one-cycle tick once per second. Each tick, while counting is enabled, moves the time forward by one second. The carry runs through the whole calendar: month lengths differ, February follows the Gregorian leap rule, and when the year passes 99 the century field moves up. The alarm offsets are decoded but do nothing: they read as zero and ignore writes.

Reset clears every register, so the clock comes up stopped, with the time words locked and the time at zero.

Top module: `cal_rtc`

## Requirements
- R1: After reset the time words and the control word read zero, so counting is off and the time words are locked.
- R2: Byte offset 0x00 (word index 0) reads the first time word: day of month in bits 28:24, hours in bits 20:16, minutes in bits 13:8, seconds in bits 5:0. All other bits read zero.
- R3: Byte offset 0x04 (word index 1) reads the second time word: century in bits 20:16, year within the century in bits 14:8, month (1 = January to 12 = December) in bits 3:0. All other bits read zero.
- R4: Byte offset 0x10 (word index 4) is the control word. Bit 0 turns counting on and bit 1 unlocks the time words. Writes to it are always accepted, and reads return bits 1:0 with all other bits zero.
- R5: A write to either time word changes nothing while control bit 1 is clear.
- R6: Reads of the alarm offset 0x08, the alarm status offset 0x14 and every unmapped offset return zero. Writes to them change no register. The two low address bits are ignored.
- R7: While control bit 0 is set, the time advances by one second every CLKS_PER_SEC clock cycles. The first advance lands CLKS_PER_SEC cycles after the edge that sets the bit. While the bit is clear the time holds and reads return the stored value.
- R8: Seconds wrap from 59 to 0 and carry into the minutes. Minutes wrap from 59 to 0 and carry into the hours. Hours wrap from 23 to 0 and carry into the day.
- R9: The day returns to 1 after the last day of its month, and the month advances. April, June, September and November have 30 days, and every other month except February has 31.
- R10: February has 29 days when the full year (century times 100 plus year) is divisible by 4 and not by 100, or is divisible by 400. Otherwise it has 28. For a year field from 0 to 99 this means: year 0 is a leap year exactly when the century is divisible by 4, and any other year is a leap year when the year is divisible by 4.
- R11: Month 12 wraps to 1 and the year increments. Year 99 wraps to 0 and the century increments.
- R12: An accepted time-word write takes effect on its own clock edge. If a tick falls on that same edge, the written value is stored as written and neither time word advances on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The bench builds the clock with CLKS_PER_SEC set to 4 and ADDR_W left at 8. A four-cycle second lets each rollover case run in a handful of cycles. It also makes it simple to place a time-word write exactly on a tick edge. Each calendar boundary is reached by loading a time one second before it and letting a single tick pass: the end of a day, 30- and 31-day months, February in a common year, a plain leap year, a year divisible by 100 but not 400, a year divisible by 400, and the end of the year and of the century. A three-tick run and a live read while counting is on confirm the pacing of the prescaler.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;

    localparam int unsigned DATA_W = 32;

    // Word indices (byte address / 4) that the decoder recognises.
    localparam int unsigned IDX_TIME_A = 0;
    localparam int unsigned IDX_TIME_B = 1;
    localparam int unsigned IDX_CTRL   = 4;

    typedef struct packed {
        logic [4:0] cent;
        logic [6:0] year;
        logic [3:0] mon;
        logic [4:0] day;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } cal_time_t;

    typedef struct packed {
        logic unlock;
        logic run;
    } cal_ctrl_t;

    typedef enum logic [1:0] {
        REG_TIME_A,
        REG_TIME_B,
        REG_CTRL,
        REG_NONE
    } cal_region_t;

    // Leap test for a year field in 0..99.
    function automatic logic is_leap(input logic [4:0] cent, input logic [6:0] year);
        if (year == 7'd0) return (cent[1:0] == 2'b00);
        return (year[1:0] == 2'b00);
    endfunction

    function automatic logic [4:0] month_len(input logic [3:0] mon, input logic leap);
        case (mon)
            4'd2:                    return leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
            default:                 return 5'd31;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pack_time_a(input cal_time_t t);
        return {3'b0, t.day, 3'b0, t.hour, 2'b0, t.min, 2'b0, t.sec};
    endfunction

    function automatic logic [DATA_W-1:0] pack_time_b(input cal_time_t t);
        return {11'b0, t.cent, 1'b0, t.year, 4'b0, t.mon};
    endfunction

endpackage

// File: rtl/cal_rtc_prescaler.sv
module cal_rtc_prescaler #(
    parameter int unsigned CLKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    generate
        if (CLKS_PER_SEC <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_count
            localparam int unsigned CW = $clog2(CLKS_PER_SEC);
            localparam logic [CW-1:0] LAST = CW'(CLKS_PER_SEC - 1);
            logic [CW-1:0] cnt_q;

            assign tick = run && (cnt_q == LAST);

            // Held at zero while stopped so the first second is a full one.
            always_ff @(posedge clk) begin
                if (rst || !run) cnt_q <= '0;
                else if (cnt_q == LAST) cnt_q <= '0;
                else cnt_q <= cnt_q + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/cal_rtc_advance.sv
module cal_rtc_advance
    import cal_rtc_pkg::*;
(
    input  cal_time_t cur,
    output cal_time_t nxt
);
    logic       c_min, c_hour, c_day, c_mon, c_year, c_cent;
    logic [4:0] last_day;

    always_comb begin
        last_day = month_len(cur.mon, is_leap(cur.cent, cur.year));
        c_min  = (cur.sec  >= 6'd59);
        c_hour = c_min  && (cur.min  >= 6'd59);
        c_day  = c_hour && (cur.hour >= 5'd23);
        c_mon  = c_day  && (cur.day  >= last_day);
        c_year = c_mon  && (cur.mon  >= 4'd12);
        c_cent = c_year && (cur.year >= 7'd99);

        nxt = cur;
        nxt.sec = c_min ? 6'd0 : cur.sec + 6'd1;
        if (c_min)  nxt.min  = c_hour ? 6'd0 : cur.min + 6'd1;
        if (c_hour) nxt.hour = c_day  ? 5'd0 : cur.hour + 5'd1;
        if (c_day)  nxt.day  = c_mon  ? 5'd1 : cur.day + 5'd1;
        if (c_mon)  nxt.mon  = c_year ? 4'd1 : cur.mon + 4'd1;
        if (c_year) nxt.year = c_cent ? 7'd0 : cur.year + 7'd1;
        if (c_cent) nxt.cent = cur.cent + 5'd1;
    end
endmodule

// File: rtl/cal_rtc_decode.sv
module cal_rtc_decode
    import cal_rtc_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              unlocked,
    output cal_region_t       region,
    output logic              wr_time_a,
    output logic              wr_time_b,
    output logic              wr_ctrl
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic [1:0]       unused_byte_lane;

    assign idx              = addr[ADDR_W-1:2];
    assign unused_byte_lane = addr[1:0];

    always_comb begin
        case (idx)
            IDX_W'(IDX_TIME_A): region = REG_TIME_A;
            IDX_W'(IDX_TIME_B): region = REG_TIME_B;
            IDX_W'(IDX_CTRL):   region = REG_CTRL;
            default:            region = REG_NONE;
        endcase
    end

    assign wr_time_a = wr && unlocked && (region == REG_TIME_A);
    assign wr_time_b = wr && unlocked && (region == REG_TIME_B);
    assign wr_ctrl   = wr && (region == REG_CTRL);
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
    import cal_rtc_pkg::*;
#(
    parameter int unsigned CLKS_PER_SEC = 32768,
    parameter int unsigned ADDR_W       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    cal_ctrl_t   ctrl_q;
    cal_time_t   tm_q;
    cal_time_t   tm_next;
    cal_region_t region;
    logic        wr_time_a, wr_time_b, wr_ctrl, wr_time;
    logic        tick;
    logic [6:0]  unused_wdata_bits;

    assign unused_wdata_bits = {bus_wdata[31:29], bus_wdata[23:21], bus_wdata[15]};
    assign wr_time = wr_time_a | wr_time_b;

    cal_rtc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr      (bus_addr),
        .wr        (bus_wr),
        .unlocked  (ctrl_q.unlock),
        .region    (region),
        .wr_time_a (wr_time_a),
        .wr_time_b (wr_time_b),
        .wr_ctrl   (wr_ctrl)
    );

    cal_rtc_prescaler #(.CLKS_PER_SEC(CLKS_PER_SEC)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_q.run),
        .tick (tick)
    );

    cal_rtc_advance u_adv (
        .cur (tm_q),
        .nxt (tm_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            tm_q   <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata[1:0];
            if (wr_time) begin
                // A software write on a tick edge wins; the tick is dropped.
                if (wr_time_a) begin
                    tm_q.day  <= bus_wdata[28:24];
                    tm_q.hour <= bus_wdata[20:16];
                    tm_q.min  <= bus_wdata[13:8];
                    tm_q.sec  <= bus_wdata[5:0];
                end
                if (wr_time_b) begin
                    tm_q.cent <= bus_wdata[20:16];
                    tm_q.year <= bus_wdata[14:8];
                    tm_q.mon  <= bus_wdata[3:0];
                end
            end else if (tick) begin
                tm_q <= tm_next;
            end
        end
    end

    always_comb begin
        case (region)
            REG_TIME_A: bus_rdata = pack_time_a(tm_q);
            REG_TIME_B: bus_rdata = pack_time_b(tm_q);
            REG_CTRL:   bus_rdata = {30'b0, ctrl_q};
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cal_rtc_checker.sv
module cal_rtc_checker
    import cal_rtc_pkg::*;
#(
    parameter int unsigned CLKS_PER_SEC = 32768,
    parameter int unsigned ADDR_W       = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-3:0] idx,
    input logic              bus_wr,
    input logic [31:0]       bus_rdata,
    input logic [5:0]        wd_sec,
    input logic [4:0]        wd_day,
    input logic [1:0]        ctrl,
    input cal_time_t         tm,
    input logic              tick,
    input logic              wr_time_a,
    input logic              wr_time
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic idx_mapped;
    logic idx_time;
    assign idx_time   = (idx == IDX_W'(IDX_TIME_A)) || (idx == IDX_W'(IDX_TIME_B));
    assign idx_mapped = idx_time || (idx == IDX_W'(IDX_CTRL));

    // R1
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl == 2'b00 && tm == '0));

    // R5
    a_r5_locked_ignore: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && idx_time && !ctrl[1] && !tick) |=> $stable(tm));

    // R6
    a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        !idx_mapped |-> (bus_rdata == 32'd0));

    // R7
    a_r7_hold_stopped: assert property (@(posedge clk) disable iff (rst)
        (!ctrl[0] && !wr_time) |=> $stable(tm));

    a_r7_tick_needs_run: assert property (@(posedge clk) disable iff (rst)
        tick |-> ctrl[0]);

    generate
        if (CLKS_PER_SEC > 1) begin : g_pulse
            a_r7_tick_single: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

    // R8
    a_r8_sec_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_time && tm.sec == 6'd59) |=> (tm.sec == 6'd0));

    // R11
    a_r11_year_end: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_time && tm.mon == 4'd12 && tm.day == 5'd31 && tm.hour == 5'd23
         && tm.min == 6'd59 && tm.sec == 6'd59) |=> (tm.mon == 4'd1 && tm.day == 5'd1));

    // R12
    a_r12_write_wins: assert property (@(posedge clk) disable iff (rst)
        wr_time_a |=> (tm.sec == $past(wd_sec) && tm.day == $past(wd_day)));
endmodule

bind cal_rtc cal_rtc_checker #(.CLKS_PER_SEC(CLKS_PER_SEC), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .idx       (bus_addr[ADDR_W-1:2]),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .wd_sec    (bus_wdata[5:0]),
    .wd_day    (bus_wdata[28:24]),
    .ctrl      (ctrl_q),
    .tm        (tm_q),
    .tick      (tick),
    .wr_time_a (wr_time_a),
    .wr_time   (wr_time)
);

// File: tb/cal_rtc_test.sv
`timescale 1ns/1ps
module cal_rtc_test;
    localparam int unsigned N = 4;
    localparam logic [7:0] A_TA = 8'h00, A_TB = 8'h04, A_AL = 8'h08, A_GAP = 8'h0C,
                           A_CT = 8'h10, A_AS = 8'h14, A_FAR = 8'h40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] cur_exp;
    string       cur_tag;

    always #4 clk = ~clk;

    cal_rtc #(.CLKS_PER_SEC(N), .ADDR_W(8)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] wa(input int d, input int h, input int m, input int s);
        return {3'b0, 5'(d), 3'b0, 5'(h), 2'b0, 6'(m), 2'b0, 6'(s)};
    endfunction

    function automatic logic [31:0] wb(input int c, input int y, input int mo);
        return {11'b0, 5'(c), 1'b0, 7'(y), 4'b0, 4'(mo)};
    endfunction

    // Monitor: compare each queued expectation mid-cycle.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            cur_exp = exp_q.pop_front();
            cur_tag = tag_q.pop_front();
            n_checks++;
            if (bus_rdata !== cur_exp) begin
                n_err++;
                $display("FAIL %s: got %h expected %h", cur_tag, bus_rdata, cur_exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic chk(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Load a time unlocked, run k seconds, stop, then compare both words.
    task automatic step(input logic [31:0] a0, input logic [31:0] b0, input int k,
                        input logic [31:0] a1, input logic [31:0] b1, input string tag);
        wr(A_CT, 32'd2);
        wr(A_TA, a0);
        wr(A_TB, b0);
        wr(A_CT, 32'd3);
        repeat (k * N - 2) @(posedge clk);
        wr(A_CT, 32'd2);
        chk(A_TA, a1, tag);
        chk(A_TB, b1, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk(A_TA, 32'd0, "R1 time word A");
        chk(A_TB, 32'd0, "R1 time word B");
        chk(A_CT, 32'd0, "R1 control");

        // R5 locked writes ignored
        wr(A_TA, wa(5, 5, 5, 5));
        wr(A_TB, wb(20, 5, 5));
        chk(A_TA, 32'd0, "R5 locked word A");
        chk(A_TB, 32'd0, "R5 locked word B");

        // R4 control readback
        wr(A_CT, 32'hFFFF_FFFF);
        chk(A_CT, 32'd3, "R4 control bits only");
        wr(A_CT, 32'd2);
        chk(A_CT, 32'd2, "R4 control unlock only");

        // R2 R3 field placement, stored value while stopped
        wr(A_TA, 32'hFFFF_FFFF & wa(15, 10, 20, 30) | 32'hE0E0_C0C0);
        wr(A_TB, wb(20, 24, 6) | 32'hFFE0_80F0);
        chk(A_TA, wa(15, 10, 20, 30), "R2 word A fields");
        chk(A_TB, wb(20, 24, 6), "R3 word B fields");

        // R7 one tick
        step(wa(15, 10, 20, 30), wb(20, 24, 6), 1, wa(15, 10, 20, 31), wb(20, 24, 6), "R7 one second");

        // R7 hold while stopped
        repeat (3 * N) @(posedge clk);
        chk(A_TA, wa(15, 10, 20, 31), "R7 hold while stopped");

        // R6 alarm and unmapped offsets
        wr(A_AL, 32'hFFFF_FFFF);
        wr(A_AS, 32'hFFFF_FFFF);
        wr(A_GAP, 32'hFFFF_FFFF);
        wr(A_FAR, 32'hFFFF_FFFF);
        chk(A_AL, 32'd0, "R6 alarm reads zero");
        chk(A_AS, 32'd0, "R6 alarm status reads zero");
        chk(A_GAP, 32'd0, "R6 gap reads zero");
        chk(A_FAR, 32'd0, "R6 far offset reads zero");
        chk(A_TA, wa(15, 10, 20, 31), "R6 word A untouched");
        chk(A_TB, wb(20, 24, 6), "R6 word B untouched");
        chk(A_CT, 32'd2, "R6 control untouched");
        chk(8'h13, 32'd2, "R6 low address bits ignored");

        // R7 several ticks
        step(wa(1, 2, 3, 58), wb(20, 24, 6), 3, wa(1, 2, 4, 1), wb(20, 24, 6), "R7 three seconds");

        // R8 carries
        step(wa(15, 10, 20, 59), wb(20, 24, 6), 1, wa(15, 10, 21, 0), wb(20, 24, 6), "R8 minute carry");
        step(wa(15, 23, 59, 59), wb(20, 24, 6), 1, wa(16, 0, 0, 0), wb(20, 24, 6), "R8 day carry");

        // R9 month lengths
        step(wa(30, 23, 59, 59), wb(20, 24, 4), 1, wa(1, 0, 0, 0), wb(20, 24, 5), "R9 30-day month");
        step(wa(30, 23, 59, 59), wb(20, 24, 1), 1, wa(31, 0, 0, 0), wb(20, 24, 1), "R9 31-day month");

        // R10 leap rules
        step(wa(28, 23, 59, 59), wb(20, 24, 2), 1, wa(29, 0, 0, 0), wb(20, 24, 2), "R10 leap 2024");
        step(wa(28, 23, 59, 59), wb(20, 23, 2), 1, wa(1, 0, 0, 0), wb(20, 23, 3), "R10 common 2023");
        step(wa(28, 23, 59, 59), wb(21, 0, 2), 1, wa(1, 0, 0, 0), wb(21, 0, 3), "R10 common 2100");
        step(wa(28, 23, 59, 59), wb(20, 0, 2), 1, wa(29, 0, 0, 0), wb(20, 0, 2), "R10 leap 2000");

        // R11 year and century
        step(wa(31, 23, 59, 59), wb(20, 24, 12), 1, wa(1, 0, 0, 0), wb(20, 25, 1), "R11 year end");
        step(wa(31, 23, 59, 59), wb(20, 99, 12), 1, wa(1, 0, 0, 0), wb(21, 0, 1), "R11 century end");

        // R12 write on the tick edge wins
        wr(A_TA, wa(9, 8, 7, 6));
        wr(A_TB, wb(19, 99, 12));
        wr(A_CT, 32'd3);
        repeat (N - 2) @(posedge clk);
        wr(A_TA, wa(31, 23, 59, 59));
        wr(A_CT, 32'd2);
        chk(A_TA, wa(31, 23, 59, 59), "R12 written word A kept");
        chk(A_TB, wb(19, 99, 12), "R12 word B not advanced");

        // R7 live read while running
        wr(A_CT, 32'd3);
        chk(A_TA, wa(31, 23, 59, 59), "R7 live before tick");
        repeat (2) @(posedge clk);
        chk(A_TA, wa(1, 0, 0, 0), "R7 live after tick");
        chk(A_TB, wb(20, 0, 1), "R11 live century roll");
        wr(A_CT, 32'd0);

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule